// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one write transaction into a page-sized staging buffer and then moves them into the storage array in a single timed operation. A protocol engine hands it bytes over a valid/ready load stream, one byte per transfer. Each byte carries its offset within the page. The engine also sends a strobe when a new write header is decoded and a strobe when the bus STOP event arrives. The page number of the target row sits on a plain input and is captured when the commit starts.

A page has 8 byte slots, and the array has 32 pages. Every slot has a valid flag, so a partial page updates only the bytes that were actually received. When a STOP finds at least one valid byte and write protection is off, the block raises `busy` for a fixed number of clock cycles, `WRITE_CYCLES`, which stands for the self-timed programming time. The array write strobe fires only in the last of those cycles, so the array never holds a half-written page. While `busy` is high the block accepts no load and ignores headers and STOP events, and the protocol engine uses `busy` to withhold its acknowledge.

Back-pressure rule: `ld_ready` is low exactly while `busy` is high. A byte is taken only in a cycle where `ld_valid` and `ld_ready` are both high. A byte offered while `ld_ready` is low is dropped, not held. The engine keeps no retry obligation, because it does not acknowledge during that time.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset `busy` is 0, `ld_ready` is 1, `arr_we` is 0, and no slot is valid: a STOP with no loads starts nothing.
- R2: `ld_ready` equals the inverse of `busy`. A byte offered while `busy` is high is not taken.
- R3: A STOP (`stop_evt` high, `busy` low) with at least one valid byte and `wr_protect` low raises `busy` from the next cycle. `busy` then stays high for exactly `WRITE_CYCLES` consecutive cycles.
- R4: `arr_we` is high for exactly one cycle per commit, the last `busy` cycle. In that cycle `arr_page` equals the `page_base` sampled with the STOP, `arr_be` bit i is 1 exactly when offset i was loaded, and byte lane i of `arr_wdata` (bits 8*i+7 down to 8*i) holds the byte loaded at offset i.
- R5: When a second byte is loaded at an offset that already holds one, it replaces the earlier byte. This covers more than 8 bytes arriving in sequence with the offset wrapping from 7 to 0.
- R6: A `hdr_start` pulse while idle clears all valid flags. Bytes loaded before it are not written by the next commit.
- R7: A STOP while no slot is valid starts no busy period and no array write.
- R8: A STOP while `wr_protect` is 1 starts no busy period and no array write, and it discards the buffered bytes.
- R9: While `busy` is high, loads, `hdr_start` and `stop_evt` have no effect. After the commit all valid flags are clear, so a following STOP with no new load starts nothing.
- R10: `arr_we` is never high while `busy` is low, and `arr_be` is all zero whenever `arr_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load stream: a byte is offered |
| ld_ready | output | 1 | Load stream: block can take a byte (low while busy) |
| ld_offset | input | 3 | Byte offset within the page for the offered byte |
| ld_data | input | 8 | Offered data byte |
| hdr_start | input | 1 | One-cycle strobe: a new write header was decoded |
| page_base | input | 5 | Target page number, sampled with the STOP |
| stop_evt | input | 1 | One-cycle strobe: bus STOP event |
| wr_protect | input | 1 | High blocks every array update |
| busy | output | 1 | Commit in progress; all requests ignored |
| arr_we | output | 1 | Array write strobe, last busy cycle only |
| arr_page | output | 5 | Page row being written |
| arr_be | output | 8 | Per-byte write enables for the page row |
| arr_wdata | output | 64 | Page data, byte lane i at bits 8*i+7:8*i |

## Verification
A byte is taken at the clock edge where `ld_valid` and `ld_ready` are both high. A STOP seen at edge E makes `busy` high from E through the following `WRITE_CYCLES` cycles. `arr_we` and its page, enables and data are valid only in the last of those cycles, and `busy` is low after the next edge. The bench drives every input at a falling edge and holds it for one cycle. It then samples the outputs once per cycle at each later falling edge. It counts `busy` cycles from the first sample after the STOP, notes the count at which `arr_we` is seen, and compares both with `WRITE_CYCLES`. For the cases that must not commit, it watches `busy` and a running count of `arr_we` pulses for well over a commit length.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // default geometry of the staging buffer and target array
  localparam int unsigned DEF_SLOTS  = 8;
  localparam int unsigned DEF_PAGES  = 32;
  localparam int unsigned DEF_DATA_W = 8;
  // 5 ms at a 125 MHz system clock
  localparam int unsigned DEF_WRITE_CYCLES = 625000;

  // width of a counter or index able to hold 0..n-1, never below 1
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pwb_slot_store.sv
module pwb_slot_store
  import pwb_pkg::*;
#(
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned OFS_W = idx_w(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [OFS_W-1:0]        wr_ofs,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr_hdr,
  input  logic                    clr_all,
  output logic [SLOTS-1:0]        mask,
  output logic [SLOTS*DATA_W-1:0] lanes
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              hit;
    logic              vld_q;
    logic [DATA_W-1:0] byte_q;

    assign hit = wr_en && (wr_ofs == OFS_W'(g));

    // valid flag: a commit end or discard wins, then a new byte, then a header clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q <= 1'b0;
      else if (clr_all) vld_q <= 1'b0;
      else if (hit)     vld_q <= 1'b1;
      else if (clr_hdr) vld_q <= 1'b0;
    end

    // data lane: the newest byte for this offset always replaces the old one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= wr_data;
    end

    assign mask[g] = vld_q;
    assign lanes[g*DATA_W +: DATA_W] = byte_q;
  end

  // R6: a header clear with no same-cycle byte leaves nothing valid
  a_r6_hdr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hdr && !wr_en |=> mask == '0);

  // R5: the most recent byte at an offset is the one held there
  a_r5_last_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr_all |=> mask[$past(wr_ofs)] &&
      (lanes[$past(wr_ofs)*DATA_W +: DATA_W] == $past(wr_data)));

endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer
  import pwb_pkg::*;
#(
  parameter int unsigned CYCLES = DEF_WRITE_CYCLES,
  localparam int unsigned CNT_W = idx_w(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        left_q <= CNT_W'(CYCLES - 1);
      end
    end else if (left_q == '0) begin
      busy <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  assign last = busy && (left_q == '0);

  // R3: the busy period does not end before its final cycle
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy);

  // R4: the final cycle is followed by idle
  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
  import pwb_pkg::*;
#(
  parameter int unsigned SLOTS        = DEF_SLOTS,
  parameter int unsigned PAGES        = DEF_PAGES,
  parameter int unsigned DATA_W       = DEF_DATA_W,
  parameter int unsigned WRITE_CYCLES = DEF_WRITE_CYCLES,
  localparam int unsigned OFS_W  = idx_w(SLOTS),
  localparam int unsigned PAGE_W = idx_w(PAGES),
  localparam int unsigned ROW_W  = SLOTS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [OFS_W-1:0]  ld_offset,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              hdr_start,
  input  logic [PAGE_W-1:0] page_base,
  input  logic              stop_evt,
  input  logic              wr_protect,
  output logic              busy,
  output logic              arr_we,
  output logic [PAGE_W-1:0] arr_page,
  output logic [SLOTS-1:0]  arr_be,
  output logic [ROW_W-1:0]  arr_wdata
);

  logic             accept;
  logic             hdr_eff;
  logic             stop_eff;
  logic             pending;
  logic             start;
  logic             discard;
  logic             last;
  logic [SLOTS-1:0] mask;
  logic [ROW_W-1:0] lanes;
  logic [PAGE_W-1:0] page_q;

  // every request is gated off while the commit runs
  assign ld_ready = !busy;
  assign accept   = ld_valid && !busy;
  assign hdr_eff  = hdr_start && !busy;
  assign stop_eff = stop_evt && !busy;

  // a byte taken in the STOP cycle still counts toward the commit
  assign pending = (|mask) || accept;
  assign start   = stop_eff && !wr_protect && pending;
  assign discard = stop_eff && wr_protect;

  pwb_slot_store #(
    .SLOTS  (SLOTS),
    .DATA_W (DATA_W)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_ofs  (ld_offset),
    .wr_data (ld_data),
    .clr_hdr (hdr_eff),
    .clr_all (last || discard),
    .mask    (mask),
    .lanes   (lanes)
  );

  pwb_commit_timer #(
    .CYCLES (WRITE_CYCLES)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_q <= '0;
    else if (start) page_q <= page_base;
  end

  assign arr_we    = last;
  assign arr_page  = page_q;
  assign arr_be    = last ? mask : '0;
  assign arr_wdata = lanes;

  // R10: array strobe only inside a busy period
  a_r10_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R10: no byte enable without the strobe
  a_r10_be_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_we |-> arr_be == '0);

  // R3: an accepted STOP with data starts the busy period next cycle
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !busy && !wr_protect && ((|mask) || ld_valid) |=> busy);

  // R7: a STOP on an empty buffer leaves the block idle
  a_r7_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !busy && !ld_valid && (mask == '0) |=> !busy);

  // R8: write protection blocks the commit and empties the buffer
  a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !busy && wr_protect |=> !busy && (mask == '0));

  // R9: buffer contents and target page frozen while busy
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !arr_we |=> $stable(mask) && $stable(lanes) && $stable(page_q));

  // R9: nothing left valid once a commit completes
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> mask == '0);

endmodule

// File: tb/test_page_commit_buffer.sv
module test_page_commit_buffer;

  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [2:0]  ld_offset = '0;
  logic [7:0]  ld_data = '0;
  logic        hdr_start = 1'b0;
  logic [4:0]  page_base = '0;
  logic        stop_evt = 1'b0;
  logic        wr_protect = 1'b0;
  logic        busy;
  logic        arr_we;
  logic [4:0]  arr_page;
  logic [7:0]  arr_be;
  logic [63:0] arr_wdata;

  int total = 0;
  int bad = 0;
  int we_cnt = 0;
  bit done = 1'b0;

  logic [7:0] exp_byte [8];
  logic [7:0] exp_be;

  page_commit_buffer #(.WRITE_CYCLES(W)) i_page_commit_buffer (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_offset(ld_offset), .ld_data(ld_data),
    .hdr_start(hdr_start), .page_base(page_base), .stop_evt(stop_evt),
    .wr_protect(wr_protect), .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
    .arr_be(arr_be), .arr_wdata(arr_wdata)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (arr_we) we_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    exp_be = '0;
    for (int i = 0; i < 8; i++) exp_byte[i] = '0;
  endtask

  task automatic load(input logic [2:0] ofs, input logic [7:0] d);
    ld_valid = 1'b1; ld_offset = ofs; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    exp_be[ofs] = 1'b1;
    exp_byte[ofs] = d;
  endtask

  task automatic send_stop();
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
  endtask

  task automatic header();
    hdr_start = 1'b1;
    @(negedge clk);
    hdr_start = 1'b0;
    exp_be = '0;
  endtask

  // STOP was just sent; busy is visible at this sample if a commit started
  task automatic watch_commit(input logic [4:0] pg, input string req);
    int n = 0;
    int we_at = 0;
    int we0 = we_cnt;
    logic [4:0]  cap_pg = '0;
    logic [7:0]  cap_be = '0;
    logic [63:0] cap_d  = '0;
    while (busy && n < 100) begin
      n++;
      if (arr_we) begin
        we_at = n; cap_pg = arr_page; cap_be = arr_be; cap_d = arr_wdata;
      end
      @(negedge clk);
    end
    chk(n == W, "R3", {req, " busy length"}, 64'(n), 64'(W));
    chk(we_at == W, "R4", {req, " strobe cycle"}, 64'(we_at), 64'(W));
    chk(we_cnt - we0 == 1, "R4", {req, " strobe count"}, 64'(we_cnt - we0), 64'd1);
    chk(cap_pg == pg, "R4", {req, " page"}, 64'(cap_pg), 64'(pg));
    chk(cap_be == exp_be, "R4", {req, " byte enables"}, 64'(cap_be), 64'(exp_be));
    for (int i = 0; i < 8; i++)
      if (exp_be[i])
        chk(cap_d[i*8 +: 8] == exp_byte[i], req, $sformatf("lane %0d", i),
            64'(cap_d[i*8 +: 8]), 64'(exp_byte[i]));
  endtask

  // no busy and no strobe for well over one commit length
  task automatic expect_idle(input string req, input string what);
    int we0 = we_cnt;
    int busy_seen = 0;
    for (int i = 0; i < 2 * W; i++) begin
      if (busy) busy_seen++;
      @(negedge clk);
    end
    chk(busy_seen == 0, req, {what, " busy cycles"}, 64'(busy_seen), 64'd0);
    chk(we_cnt == we0, req, {what, " strobes"}, 64'(we_cnt - we0), 64'd0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    chk(ld_ready == 1'b1, "R1", "reset ready", 64'(ld_ready), 64'd1);
    chk(arr_we == 1'b0, "R1", "reset strobe", 64'(arr_we), 64'd0);
    send_stop();
    expect_idle("R1", "stop after reset");
  endtask

  task automatic t_full_page();
    clear_exp();
    header();
    for (int i = 0; i < 8; i++) load(3'(i), 8'(8'h30 + 8'(i * 7)));
    page_base = 5'd5;
    send_stop();
    watch_commit(5'd5, "R4 full");
  endtask

  task automatic t_partial();
    clear_exp();
    header();
    load(3'd1, 8'hA1);
    load(3'd6, 8'h6E);
    page_base = 5'd31;
    send_stop();
    watch_commit(5'd31, "R4 partial");
  endtask

  task automatic t_wrap();
    clear_exp();
    header();
    for (int i = 0; i < 10; i++) load(3'((2 + i) % 8), 8'(8'h90 + 8'(i)));
    // offsets 2 and 3 were written twice; the second bytes must win (R5)
    page_base = 5'd0;
    send_stop();
    watch_commit(5'd0, "R5 wrap");
  endtask

  task automatic t_header_clear();
    clear_exp();
    load(3'd0, 8'h11);
    load(3'd1, 8'h22);
    header();
    load(3'd4, 8'h44);
    page_base = 5'd12;
    send_stop();
    watch_commit(5'd12, "R6 header");
  endtask

  task automatic t_empty_stop();
    clear_exp();
    header();
    send_stop();
    expect_idle("R7", "empty stop");
  endtask

  task automatic t_protect();
    clear_exp();
    header();
    load(3'd2, 8'h55);
    wr_protect = 1'b1;
    send_stop();
    expect_idle("R8", "protected stop");
    wr_protect = 1'b0;
    send_stop();
    expect_idle("R8", "stop after discard");
  endtask

  task automatic t_busy_ignore();
    clear_exp();
    header();
    load(3'd3, 8'h3C);
    page_base = 5'd7;
    send_stop();
    chk(ld_ready == 1'b0, "R2", "ready while busy", 64'(ld_ready), 64'd0);
    // requests during busy: must change neither enables nor page (R9)
    ld_valid = 1'b1; ld_offset = 3'd5; ld_data = 8'hEE; page_base = 5'd9;
    @(negedge clk);
    ld_valid = 1'b0; ld_offset = 3'd3; ld_data = 8'hFF;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    hdr_start = 1'b1;
    @(negedge clk);
    hdr_start = 1'b0;
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    // four of W busy cycles consumed; watch the rest by hand
    begin
      int n = 4;
      int we_at = 0;
      logic [7:0] cb = '0;
      logic [63:0] cd = '0;
      logic [4:0] cp = '0;
      while (busy && n < 100) begin
        n++;
        if (arr_we) begin we_at = n; cb = arr_be; cd = arr_wdata; cp = arr_page; end
        @(negedge clk);
      end
      chk(n == W, "R9", "busy length with requests", 64'(n), 64'(W));
      chk(we_at == W, "R9", "strobe cycle with requests", 64'(we_at), 64'(W));
      chk(cb == 8'h08, "R9", "enables ignore busy loads", 64'(cb), 64'h08);
      chk(cd[24 +: 8] == 8'h3C, "R2", "busy load not taken", 64'(cd[24 +: 8]), 64'h3C);
      chk(cp == 5'd7, "R9", "page held", 64'(cp), 64'd7);
    end
    send_stop();
    expect_idle("R9", "stop after commit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_page();
    t_partial();
    t_wrap();
    t_header_clear();
    t_empty_stop();
    t_protect();
    t_busy_ignore();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule